// File: doc/BRIEF.md
# Snooping Write-Back Data Cache

This block is a small direct-mapped write-back data cache that sits between a CPU request port and a main-memory channel. The same memory channel also carries the transfers of an I/O (DMA) agent. The cache arbitrates that channel. It looks up every I/O transfer against its own tag array, so that the I/O agent never reads a stale value from memory and never leaves an outdated copy in the cache.

Each of the 16 lines holds 4 words and has a valid bit and a dirty bit. When an I/O write hits a cached line, that line is invalidated, and any modified data in it is written back first. When an I/O read hits a modified line, the cache answers the read itself. A configurable window of word addresses is non-cacheable: CPU accesses to it go straight to memory. A flush command writes back every modified line and then empties the cache.

Addresses are word addresses. The word offset is bits [1:0], the line index is bits [5:2], and the tag is the bits above them. The memory channel accepts a request every cycle. Write data is taken in the request cycle, and read data returns in the cycle after the request.

Top module: `snoop_cache`

## Requirements
- R1: After reset, cpu_ready, io_ack, mem_req and flush_done are 0 and every line is invalid, so the first CPU read of each line fetches all 4 of its words from memory.
- R2: A cacheable CPU read returns the current value of the addressed word. A repeated read of a resident line makes no memory access.
- R3: A cacheable CPU write updates only the cached copy and marks the line dirty. Memory is not written in that operation.
- R4: A miss whose victim line is dirty first writes all 4 victim words back to their own addresses, and only then refills the line.
- R5: An I/O write is placed on the memory channel in its io_ack cycle with the I/O address and data. If the line holding that address is dirty, it is written back first. A cached copy of that line is invalidated, so a later CPU read returns the I/O value.
- R6: An I/O read that hits a dirty line returns the cached word with io_ack and makes no memory access. Any other I/O read returns the memory word, with io_ack in the cycle after its request.
- R7: CPU accesses to word addresses from NC_LO to NC_HI inclusive go to memory and allocate no line. A write reaches memory in its cpu_ready cycle. A read always returns the memory contents. Addresses just outside the window are cached.
- R8: When an I/O request and a CPU request are both pending with the cache idle, the I/O request is served first. cpu_ready and io_ack are never high in the same cycle.
- R9: A held flush_req writes back every dirty line (4 words each) and clears every valid bit. It then raises flush_done for exactly one cycle.
- R10: cpu_ready is only asserted while cpu_req is high, and io_ack only while io_req is high. A requester holds its request and operands stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, valid with cpu_ready |
| cpu_ready | output | 1 | CPU access completes this cycle |
| io_req | input | 1 | I/O agent transfer request, held until io_ack |
| io_we | input | 1 | I/O transfer is a write |
| io_addr | input | AW | I/O word address |
| io_wdata | input | DW | I/O write data |
| io_rdata | output | DW | I/O read data, valid with io_ack |
| io_ack | output | 1 | I/O transfer completes this cycle |
| flush_req | input | 1 | Flush command, held until flush_done |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory channel request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read request |

## Verification
The two functions that can fall in the same cycle are the CPU tag lookup and the snoop lookup of an I/O transfer. The bench provokes this by raising cpu_req and io_req on the same clock edge, both aimed at the same word. In one case the target line is dirty and the I/O agent writes while the CPU reads. In the other case the I/O agent reads while the CPU writes. The outcome is judged by the order of io_ack and cpu_ready and by the values each side receives. The CPU must see the I/O write, and the I/O read must see the value from before the CPU write; a second I/O read must then get the CPU value straight from the cache.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  typedef enum logic [2:0] {
    SC_IDLE,
    SC_IO_RD,
    SC_NC_RD,
    SC_WB,
    SC_FILL,
    SC_FILL_END,
    SC_FLUSH
  } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
`timescale 1ns/1ps
module sc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic [$clog2(LINES)-1:0] lk_idx,
  output logic                     lk_valid,
  output logic                     lk_dirty,
  output logic [TAG_W-1:0]         lk_tag,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] w_idx,
  input  logic                     w_valid,
  input  logic                     w_dirty,
  input  logic [TAG_W-1:0]         w_tag
);
  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] dirty_vec;
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             v_q, d_q;
    logic [TAG_W-1:0] t_q;
    logic             sel;
    assign sel = we && (w_idx == i[$clog2(LINES)-1:0]);

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= w_valid;
        d_q <= w_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) t_q <= w_tag;
    end

    assign valid_vec[i] = v_q;
    assign dirty_vec[i] = d_q;
    assign tag_arr[i]   = t_q;
  end

  assign lk_valid = valid_vec[lk_idx];
  assign lk_dirty = dirty_vec[lk_idx];
  assign lk_tag   = tag_arr[lk_idx];
endmodule

// File: rtl/sc_data_store.sv
`timescale 1ns/1ps
module sc_data_store #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic [$clog2(LINES)-1:0] r_idx,
  input  logic [$clog2(WORDS)-1:0] r_off,
  output logic [DW-1:0]            r_data,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] w_idx,
  input  logic [$clog2(WORDS)-1:0] w_off,
  input  logic [DW-1:0]            w_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int N     = LINES * WORDS;

  logic [DW-1:0] word_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we && ({w_idx, w_off} == i[IDX_W+OFF_W-1:0])) q <= w_data;
    end
    assign word_arr[i] = q;
  end

  assign r_data = word_arr[{r_idx, r_off}];
endmodule

// File: rtl/snoop_cache.sv
`timescale 1ns/1ps
module snoop_cache
  import sc_pkg::*;
#(
  parameter int             AW    = 10,
  parameter int             DW    = 32,
  parameter int             LINES = 16,
  parameter int             WORDS = 4,
  parameter logic [AW-1:0]  NC_LO = 10'h380,
  parameter logic [AW-1:0]  NC_HI = 10'h3BF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  input  logic          io_req,
  input  logic          io_we,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_ack,
  input  logic          flush_req,
  output logic          flush_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = AW - IDX_W - OFF_W;
  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(LINES - 1);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_ni   <= rst_s0_q;
    end
  end

  // address fields
  logic [TAG_W-1:0] cpu_tag, io_tag;
  logic [IDX_W-1:0] cpu_idx, io_idx;
  logic [OFF_W-1:0] cpu_off, io_off;
  logic             cpu_nc;
  assign {cpu_tag, cpu_idx, cpu_off} = cpu_addr;
  assign {io_tag, io_idx, io_off}    = io_addr;
  assign cpu_nc = (cpu_addr >= NC_LO) && (cpu_addr <= NC_HI);

  // state
  sc_state_e        state_q, state_d, ret_q, ret_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0] line_q, line_d;

  // store interfaces
  logic [IDX_W-1:0] lk_idx;
  logic             lk_valid, lk_dirty;
  logic [TAG_W-1:0] lk_tag;
  logic             tg_we, tg_wvalid, tg_wdirty;
  logic [IDX_W-1:0] tg_widx;
  logic [TAG_W-1:0] tg_wtag;
  logic [IDX_W-1:0] rd_idx;
  logic [OFF_W-1:0] rd_off;
  logic [DW-1:0]    rd_data;
  logic             dat_we;
  logic [IDX_W-1:0] dat_widx;
  logic [OFF_W-1:0] dat_woff;
  logic [DW-1:0]    dat_wdata;

  sc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_ni(rst_ni),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
    .we(tg_we), .w_idx(tg_widx), .w_valid(tg_wvalid), .w_dirty(tg_wdirty), .w_tag(tg_wtag)
  );

  sc_data_store #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk),
    .r_idx(rd_idx), .r_off(rd_off), .r_data(rd_data),
    .we(dat_we), .w_idx(dat_widx), .w_off(dat_woff), .w_data(dat_wdata)
  );

  // lookup port selection: the snoop has the tag array first when idle
  always_comb begin
    unique case (state_q)
      SC_IDLE:             lk_idx = io_req ? io_idx : cpu_idx;
      SC_WB, SC_FLUSH:     lk_idx = line_q;
      default:             lk_idx = cpu_idx;
    endcase
    if (state_q == SC_WB) begin
      rd_idx = line_q;
      rd_off = beat_q;
    end else if (io_req) begin
      rd_idx = io_idx;
      rd_off = io_off;
    end else begin
      rd_idx = cpu_idx;
      rd_off = cpu_off;
    end
  end

  assign cpu_rdata = (state_q == SC_NC_RD) ? mem_rdata : rd_data;
  assign io_rdata  = (state_q == SC_IO_RD) ? mem_rdata : rd_data;

  // next-state and outputs
  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    beat_d     = beat_q;
    line_d     = line_q;
    cpu_ready  = 1'b0;
    io_ack     = 1'b0;
    flush_done = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cpu_addr;
    mem_wdata  = cpu_wdata;
    tg_we      = 1'b0;
    tg_widx    = lk_idx;
    tg_wvalid  = 1'b0;
    tg_wdirty  = 1'b0;
    tg_wtag    = lk_tag;
    dat_we     = 1'b0;
    dat_widx   = cpu_idx;
    dat_woff   = cpu_off;
    dat_wdata  = cpu_wdata;

    unique case (state_q)
      SC_IDLE: begin
        if (io_req) begin
          if (lk_valid && lk_tag == io_tag && lk_dirty) begin
            if (io_we) begin
              line_d  = io_idx;
              beat_d  = '0;
              ret_d   = SC_IDLE;
              state_d = SC_WB;
            end else begin
              io_ack = 1'b1;
            end
          end else if (io_we) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = io_addr;
            mem_wdata = io_wdata;
            io_ack    = 1'b1;
            if (lk_valid && lk_tag == io_tag) begin
              tg_we = 1'b1;
            end
          end else begin
            mem_req  = 1'b1;
            mem_addr = io_addr;
            state_d  = SC_IO_RD;
          end
        end else if (flush_req) begin
          line_d  = '0;
          state_d = SC_FLUSH;
        end else if (cpu_req) begin
          if (cpu_nc) begin
            mem_req = 1'b1;
            mem_we  = cpu_we;
            if (cpu_we) cpu_ready = 1'b1;
            else        state_d   = SC_NC_RD;
          end else if (lk_valid && lk_tag == cpu_tag) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              dat_we    = 1'b1;
              tg_we     = 1'b1;
              tg_wvalid = 1'b1;
              tg_wdirty = 1'b1;
            end
          end else if (lk_valid && lk_dirty) begin
            line_d  = cpu_idx;
            beat_d  = '0;
            ret_d   = SC_IDLE;
            state_d = SC_WB;
          end else begin
            tg_we   = 1'b1;
            tg_wtag = cpu_tag;
            beat_d  = '0;
            state_d = SC_FILL;
          end
        end
      end
      SC_IO_RD: begin
        io_ack  = 1'b1;
        state_d = SC_IDLE;
      end
      SC_NC_RD: begin
        cpu_ready = 1'b1;
        state_d   = SC_IDLE;
      end
      SC_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {lk_tag, line_q, beat_q};
        mem_wdata = rd_data;
        beat_d    = beat_q + 1'b1;
        if (beat_q == LAST_BEAT) begin
          tg_we     = 1'b1;
          tg_wvalid = lk_valid;
          state_d   = ret_q;
        end
      end
      SC_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {cpu_tag, cpu_idx, beat_q};
        beat_d   = beat_q + 1'b1;
        if (beat_q != '0) begin
          dat_we    = 1'b1;
          dat_woff  = beat_q - 1'b1;
          dat_wdata = mem_rdata;
        end
        if (beat_q == LAST_BEAT) state_d = SC_FILL_END;
      end
      SC_FILL_END: begin
        dat_we    = 1'b1;
        dat_woff  = LAST_BEAT;
        dat_wdata = mem_rdata;
        tg_we     = 1'b1;
        tg_wvalid = 1'b1;
        tg_wtag   = cpu_tag;
        state_d   = SC_IDLE;
      end
      SC_FLUSH: begin
        if (lk_valid && lk_dirty) begin
          beat_d  = '0;
          ret_d   = SC_FLUSH;
          state_d = SC_WB;
        end else begin
          tg_we = 1'b1;
          if (line_q == LAST_LINE) begin
            flush_done = 1'b1;
            state_d    = SC_IDLE;
          end else begin
            line_d = line_q + 1'b1;
          end
        end
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_IDLE;
      ret_q   <= SC_IDLE;
      beat_q  <= '0;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      beat_q  <= beat_d;
      line_q  <= line_d;
    end
  end
endmodule

// File: rtl/sc_checker.sv
`timescale 1ns/1ps
module sc_checker
  import sc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic          cpu_nc,
  input logic          io_req,
  input logic          io_we,
  input logic          io_ack,
  input logic [AW-1:0] io_addr,
  input logic [DW-1:0] io_wdata,
  input logic          flush_req,
  input logic          flush_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input sc_state_e     state_q,
  input logic          tg_we
);
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cpu_ready && io_ack));

  a_r10_cpu_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_ready |-> cpu_req);

  a_r10_io_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_ni)
    io_ack |-> io_req);

  a_r5_io_write_forward: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_ack && io_we) |-> (mem_req && mem_we && mem_addr == io_addr && mem_wdata == io_wdata));

  a_r3_write_hit_local: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_ready && cpu_we && !cpu_nc) |-> !mem_req);

  a_r7_nc_no_alloc: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SC_IDLE && !io_req && !flush_req && cpu_req && cpu_nc) |-> !tg_we);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_done |=> !flush_done);

  a_r4_fill_reads: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SC_FILL) |-> (mem_req && !mem_we));
endmodule

bind snoop_cache sc_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_ni(rst_ni),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready), .cpu_nc(cpu_nc),
  .io_req(io_req), .io_we(io_we), .io_ack(io_ack), .io_addr(io_addr), .io_wdata(io_wdata),
  .flush_req(flush_req), .flush_done(flush_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .state_q(state_q), .tg_we(tg_we)
);

// File: tb/tb_snoop_cache.sv
`timescale 1ns/1ps
module tb_snoop_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, io_req, io_we, flush_req;
  logic [9:0]  cpu_addr, io_addr;
  logic [31:0] cpu_wdata, io_wdata;
  logic [31:0] cpu_rdata, io_rdata;
  logic        cpu_ready, io_ack, flush_done;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  snoop_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_ack(io_ack),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // main memory model: one request per cycle, read data one cycle later
  logic [31:0] mem [1024];
  logic [31:0] refm [1024];
  int          mem_rd_n, mem_wr_n, cyc_n;
  logic        bd_en;
  logic [9:0]  bd_addr;
  logic [31:0] bd_data;

  function automatic logic [31:0] init_val(input int a);
    return 32'h5A00_0000 + 32'(a) * 32'd7919;
  endfunction

  function automatic logic [9:0] mk(input int t, input int i, input int o);
    return 10'((t << 6) | (i << 2) | o);
  endfunction

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (!rst_n) begin
      for (int a = 0; a < 1024; a++) mem[a] <= init_val(a);
      mem_rd_n <= 0;
      mem_wr_n <= 0;
    end else begin
      if (mem_req) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          mem_wr_n <= mem_wr_n + 1;
        end else begin
          mem_rd_n <= mem_rd_n + 1;
        end
        mem_rdata <= mem[mem_addr];
      end
      if (bd_en) mem[bd_addr] <= bd_data;
    end
  end

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [9:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int t);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_ready) begin rd = cpu_rdata; t = cyc_n; break; end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic io_op(input logic we, input logic [9:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int t);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_wdata = wd;
    forever begin
      #1;
      if (io_ack) begin rd = io_rdata; t = cyc_n; break; end
      @(negedge clk);
    end
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0;
  endtask

  task automatic backdoor(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_en = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_en = 1'b0;
    refm[a] = d;
  endtask

  logic [31:0] rd, rd2;
  int          t1, t2, base;

  initial begin
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    io_req = 0; io_we = 0; io_addr = 0; io_wdata = 0; flush_req = 0;
    bd_en = 0; bd_addr = 0; bd_data = 0; cyc_n = 0;
    for (int a = 0; a < 1024; a++) refm[a] = init_val(a);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 cpu_ready", 32'(cpu_ready), 0);
    chk("R1 io_ack", 32'(io_ack), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 flush_done", 32'(flush_done), 0);

    // R1/R2 cold sweep, then warm sweep
    base = mem_rd_n;
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 4; o++) begin
        cpu_op(1'b0, mk(1, i, o), 0, rd, t1);
        chk("R2 cold read", rd, refm[mk(1, i, o)]);
      end
    chk("R1 cold fill count", 32'(mem_rd_n - base), 64);
    base = mem_rd_n;
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 4; o++) begin
        cpu_op(1'b0, mk(1, i, o), 0, rd, t1);
        chk("R2 warm read", rd, refm[mk(1, i, o)]);
      end
    chk("R2 warm no memory", 32'(mem_rd_n - base), 0);

    // R3 write-back
    base = mem_wr_n;
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 4; o++) begin
        cpu_op(1'b1, mk(1, i, o), 32'hC000_0000 | (i << 8) | o, rd, t1);
        refm[mk(1, i, o)] = 32'hC000_0000 | (i << 8) | o;
      end
    chk("R3 no memory writes", 32'(mem_wr_n - base), 0);
    chk("R3 memory still old", mem[mk(1, 3, 2)], init_val(int'(mk(1, 3, 2))));
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 4; o++) begin
        cpu_op(1'b0, mk(1, i, o), 0, rd, t1);
        chk("R3 readback", rd, refm[mk(1, i, o)]);
      end

    // R4 dirty eviction
    base = mem_wr_n;
    for (int i = 0; i < 16; i++) begin
      cpu_op(1'b0, mk(2, i, 0), 0, rd, t1);
      chk("R4 conflict read", rd, refm[mk(2, i, 0)]);
    end
    chk("R4 writeback count", 32'(mem_wr_n - base), 64);
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 4; o++)
        chk("R4 written back", mem[mk(1, i, o)], refm[mk(1, i, o)]);

    // R6 I/O reads: dirty lines supplied by the cache
    for (int i = 0; i < 8; i++) begin
      cpu_op(1'b1, mk(2, i, 0), 32'hD000_0000 | i, rd, t1);
      refm[mk(2, i, 0)] = 32'hD000_0000 | i;
    end
    base = mem_rd_n;
    for (int i = 0; i < 8; i++) begin
      io_op(1'b0, mk(2, i, 0), 0, rd, t1);
      chk("R6 dirty supply", rd, refm[mk(2, i, 0)]);
    end
    chk("R6 no memory read", 32'(mem_rd_n - base), 0);
    io_op(1'b0, mk(2, 8, 1), 0, rd, t1);
    chk("R6 clean hit from memory", rd, refm[mk(2, 8, 1)]);
    chk("R6 one memory read", 32'(mem_rd_n - base), 1);
    io_op(1'b0, mk(1, 5, 3), 0, rd, t1);
    chk("R6 miss from memory", rd, refm[mk(1, 5, 3)]);

    // R5 I/O writes
    io_op(1'b1, mk(2, 8, 1), 32'hE000_0001, rd, t1);
    refm[mk(2, 8, 1)] = 32'hE000_0001;
    chk("R5 memory gets io data", mem[mk(2, 8, 1)], 32'hE000_0001);
    cpu_op(1'b0, mk(2, 8, 1), 0, rd, t1);
    chk("R5 cpu sees io write", rd, 32'hE000_0001);
    io_op(1'b1, mk(2, 0, 2), 32'hE000_0002, rd, t1);
    refm[mk(2, 0, 2)] = 32'hE000_0002;
    chk("R5 dirty word written back", mem[mk(2, 0, 0)], refm[mk(2, 0, 0)]);
    chk("R5 io word in memory", mem[mk(2, 0, 2)], 32'hE000_0002);
    cpu_op(1'b0, mk(2, 0, 2), 0, rd, t1);
    chk("R5 cpu sees io word", rd, 32'hE000_0002);
    cpu_op(1'b0, mk(2, 0, 0), 0, rd, t1);
    chk("R5 cpu keeps own word", rd, refm[mk(2, 0, 0)]);

    // R8 simultaneous snoop and cpu lookup
    fork
      cpu_op(1'b0, mk(2, 1, 0), 0, rd, t1);
      io_op(1'b1, mk(2, 1, 0), 32'hE000_0003, rd2, t2);
    join
    refm[mk(2, 1, 0)] = 32'hE000_0003;
    chk("R8 io served first", 32'(t2 < t1), 1);
    chk("R8 cpu reads io value", rd, 32'hE000_0003);
    fork
      cpu_op(1'b1, mk(2, 1, 0), 32'hF000_0004, rd, t1);
      io_op(1'b0, mk(2, 1, 0), 0, rd2, t2);
    join
    chk("R8 io first again", 32'(t2 < t1), 1);
    chk("R8 io read old value", rd2, 32'hE000_0003);
    refm[mk(2, 1, 0)] = 32'hF000_0004;
    base = mem_rd_n;
    io_op(1'b0, mk(2, 1, 0), 0, rd2, t2);
    chk("R8 io read new value", rd2, 32'hF000_0004);
    chk("R6 supply without memory", 32'(mem_rd_n - base), 0);
    #1;
    chk("R10 ready low after req", 32'(cpu_ready | io_ack), 0);

    // R7 non-cacheable window
    for (int k = 0; k < 8; k++) begin
      logic [9:0] na;
      na = 10'h380 + 10'(k * 9);
      base = mem_wr_n;
      cpu_op(1'b1, na, 32'hAB00_0000 | k, rd, t1);
      chk("R7 nc write direct", mem[na], 32'hAB00_0000 | k);
      chk("R7 nc one write", 32'(mem_wr_n - base), 1);
      backdoor(na, 32'hAC00_0000 | k);
      cpu_op(1'b0, na, 0, rd, t1);
      chk("R7 nc read fresh", rd, 32'hAC00_0000 | k);
      backdoor(na, 32'hAD00_0000 | k);
      cpu_op(1'b0, na, 0, rd, t1);
      chk("R7 nc read fresh again", rd, 32'hAD00_0000 | k);
    end
    cpu_op(1'b1, 10'h3BF, 32'h1234_5678, rd, t1);
    chk("R7 upper edge in window", mem[10'h3BF], 32'h1234_5678);
    refm[10'h3BF] = 32'h1234_5678;
    base = mem_wr_n;
    cpu_op(1'b1, 10'h37F, 32'h0BAD_0001, rd, t1);
    cpu_op(1'b1, 10'h3C0, 32'h0BAD_0002, rd, t1);
    chk("R7 outside window cached", 32'(mem_wr_n - base), 0);
    chk("R7 below edge memory old", mem[10'h37F], refm[10'h37F]);

    // R9 flush
    for (int i = 0; i < 16; i++) begin
      cpu_op(1'b1, mk(3, i, 0), 32'h7700_0000 | i, rd, t1);
      refm[mk(3, i, 0)] = 32'h7700_0000 | i;
    end
    base = mem_wr_n;
    @(negedge clk) flush_req = 1'b1;
    forever begin
      #1;
      if (flush_done) break;
      @(negedge clk);
    end
    @(negedge clk) flush_req = 1'b0;
    #1;
    chk("R9 done one cycle", 32'(flush_done), 0);
    chk("R9 writeback count", 32'(mem_wr_n - base), 64);
    for (int i = 0; i < 16; i++)
      chk("R9 dirty data in memory", mem[mk(3, i, 0)], 32'h7700_0000 | i);
    for (int i = 0; i < 16; i++) backdoor(mk(3, i, 0), 32'h6600_0000 | i);
    base = mem_rd_n;
    for (int i = 0; i < 16; i++) begin
      cpu_op(1'b0, mk(3, i, 0), 0, rd, t1);
      chk("R9 lines invalid after flush", rd, 32'h6600_0000 | i);
    end
    chk("R9 refetch count", 32'(mem_rd_n - base), 64);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched + 1);
    $finish;
  end
endmodule